// File: doc/BRIEF.md
# Lock Register Command Sequencer

This block decodes write cycles on a 16-bit memory bus to reach a small one-time-programmable lock register. After reset it sits in array-read mode, where every read returns a fixed array pattern. Three unlock writes switch it into a lock-register command mode. In that mode the register can be read back, programmed or left again.

Programming is one-way. A program can only clear bits, and a cleared bit stays cleared. Bit 1 (persistent-mode lock) and bit 2 (password-mode lock) must not be cleared by the same program. A program word that has both of these bits at 0 is rejected. The register keeps its value and the block drops back to array-read mode. Any write that does not fit the expected sequence also returns the decoder to array-read mode. The model has no nonvolatile storage, so reset reloads the erased value FFFFh.

Top module: `lockreg_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode (`in_cmd_mode` = 0) and the lock register holds FFFFh.
- R2: The writes (addr 555h, data AAh), then (2AAh, 55h), then (555h, 40h) enter command mode. `in_cmd_mode` rises after the third write.
- R3: In command mode, a read whose address low byte is 00h returns the lock register. A read at any other address returns the array pattern. With `rd_en` low, `rd_data` is 0000h.
- R4: In command mode, a write of A0h to any address followed by a write of value V sets the register to old AND V, and the block stays in command mode.
- R5: A bit of the lock register that is 0 never returns to 1 except through reset.
- R6: If V has bit 1 and bit 2 both at 0, the program aborts. The register is unchanged and the block returns to array-read mode.
- R7: In command mode, a write of 90h followed by a write of 00h returns the block to array-read mode.
- R8: A write that breaks the unlock sequence, or an unknown command byte in command mode, returns the decoder to array-read mode.
- R9: During unlock and command cycles, data bits 15:8 and address bits above bit 10 are ignored.
- R10: In array-read mode, every read returns the array pattern 5AA5h, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data (combinational) |
| in_cmd_mode | output | 1 | High while in lock-register command mode |

## Verification
The assertions check the following on every cycle:
- no cleared register bit is ever set again;
- a committed program leaves exactly the AND of the old value and the written word;
- an abort leaves the register untouched and drops command mode;
- a completed exit ends command mode;
- reads in array-read mode, and reads with the strobe low, return the fixed values.

Only the bench scenarios can show that the correct three-write preamble is needed and sufficient. They also show that broken sequences, ignored high data and address bits, and the abort path lead to the right externally visible read-back values over whole command sequences.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int DATA_W   = 16;
  localparam int CMP_AW   = 11;

  localparam logic [CMP_AW-1:0] UNLOCK_A0 = 11'h555;
  localparam logic [CMP_AW-1:0] UNLOCK_A1 = 11'h2AA;
  localparam logic [7:0] UNLOCK_D0 = 8'hAA;
  localparam logic [7:0] UNLOCK_D1 = 8'h55;
  localparam logic [7:0] ENTRY_CODE = 8'h40;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_EXIT0   = 8'h90;
  localparam logic [7:0] OP_EXIT1   = 8'h00;

  typedef enum logic [2:0] {
    ST_ARRAY, ST_UNL1, ST_UNL2, ST_CMD, ST_PRG, ST_EXIT
  } lrs_state_e;

  function automatic logic cyc_match(input logic [CMP_AW-1:0] a, input logic [7:0] d,
                                     input logic [CMP_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic mode_conflict(input logic [DATA_W-1:0] v);
    return !v[1] && !v[2];
  endfunction

  function automatic logic [DATA_W-1:0] otp_merge(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] v);
    return old & v;
  endfunction
endpackage

// File: rtl/lrs_decode.sv
module lrs_decode
  import lrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMP_AW-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output lrs_state_e        state_q,
  output logic              prog_commit,
  output logic              prog_abort
);
  lrs_state_e state_d;
  logic [7:0] cmd;

  assign cmd = wdata[7:0];

  always_comb begin
    state_d     = state_q;
    prog_commit = 1'b0;
    prog_abort  = 1'b0;
    if (wr_en) begin
      state_d = ST_ARRAY;
      unique case (state_q)
        ST_ARRAY: if (cyc_match(addr_lo, cmd, UNLOCK_A0, UNLOCK_D0)) state_d = ST_UNL1;
        ST_UNL1:  if (cyc_match(addr_lo, cmd, UNLOCK_A1, UNLOCK_D1)) state_d = ST_UNL2;
        ST_UNL2:  if (cyc_match(addr_lo, cmd, UNLOCK_A0, ENTRY_CODE)) state_d = ST_CMD;
        ST_CMD: begin
          if (cmd == OP_PROGRAM)    state_d = ST_PRG;
          else if (cmd == OP_EXIT0) state_d = ST_EXIT;
        end
        ST_PRG: begin
          if (mode_conflict(wdata)) begin
            prog_abort = 1'b1;
          end else begin
            prog_commit = 1'b1;
            state_d     = ST_CMD;
          end
        end
        ST_EXIT: state_d = ST_ARRAY;
        default: state_d = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARRAY;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lrs_otp_reg.sv
module lrs_otp_reg
  import lrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= '1;
    else if (commit) lock_q <= otp_merge(lock_q, wdata);
  end
endmodule

// File: rtl/lrs_rdmux.sv
module lrs_rdmux
  import lrs_pkg::*;
#(
  parameter logic [DATA_W-1:0] ARRAY_PAT = 16'h5AA5
) (
  input  logic              rd_en,
  input  logic              in_cmd,
  input  logic [7:0]        addr_lo,
  input  logic [DATA_W-1:0] lock_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    if (!rd_en)                         rd_data = '0;
    else if (in_cmd && addr_lo == 8'h00) rd_data = lock_q;
    else                                rd_data = ARRAY_PAT;
  end
endmodule

// File: rtl/lockreg_cmd_seq.sv
module lockreg_cmd_seq
  import lrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [15:0] ARRAY_PAT = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  output logic              in_cmd_mode
);
  lrs_state_e        state_q;
  logic              prog_commit;
  logic              prog_abort;
  logic [DATA_W-1:0] lock_q;

  lrs_decode u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr_lo(bus_addr[CMP_AW-1:0]), .wdata(bus_wdata),
    .state_q(state_q), .prog_commit(prog_commit), .prog_abort(prog_abort)
  );

  lrs_otp_reg u_otp (
    .clk(clk), .rst_n(rst_n), .commit(prog_commit),
    .wdata(bus_wdata), .lock_q(lock_q)
  );

  assign in_cmd_mode = (state_q == ST_CMD) || (state_q == ST_PRG) || (state_q == ST_EXIT);

  lrs_rdmux #(.ARRAY_PAT(ARRAY_PAT)) u_rdmux (
    .rd_en(rd_en), .in_cmd(in_cmd_mode), .addr_lo(bus_addr[7:0]),
    .lock_q(lock_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
  import lrs_pkg::*;
#(
  parameter logic [15:0] ARRAY_PAT = 16'h5AA5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] wdata,
  input logic [15:0] rd_data,
  input logic        in_cmd_mode,
  input lrs_state_e  state_q,
  input logic [15:0] lock_q,
  input logic        prog_commit,
  input logic        prog_abort
);
  assert_never_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & ~$past(lock_q)) == 16'h0000));

  assert_commit_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |=> (in_cmd_mode && lock_q == ($past(lock_q) & $past(wdata))));

  assert_abort_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_abort |=> (!in_cmd_mode && $stable(lock_q)));

  assert_exit_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && state_q == ST_EXIT) |=> !in_cmd_mode);

  assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 16'h0000);

  assert_array_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_cmd_mode) |-> rd_data == ARRAY_PAT);

  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_commit, prog_abort}));
endmodule

bind lockreg_cmd_seq lrs_checker #(.ARRAY_PAT(ARRAY_PAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(bus_wdata),
  .rd_data(rd_data), .in_cmd_mode(in_cmd_mode), .state_q(state_q),
  .lock_q(lock_q), .prog_commit(prog_commit), .prog_abort(prog_abort)
);

// File: tb/lockreg_cmd_seq_tb_top.sv
module lockreg_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PAT = 16'h5AA5;
  localparam int NVEC = 26;

  // {req[3:0], is_read, addr[15:0], data[15:0], expected read[15:0], expected mode}
  localparam logic [53:0] VEC [NVEC] = '{
    {4'd10, 1'b1, 16'h0000, 16'h0000, 16'h5AA5, 1'b0}, // R10 array read after reset
    {4'd2,  1'b0, 16'h0555, 16'h00AA, 16'h0000, 1'b0}, // R2 unlock 1
    {4'd2,  1'b0, 16'h02AA, 16'h0055, 16'h0000, 1'b0}, // R2 unlock 2
    {4'd2,  1'b0, 16'h0555, 16'h0040, 16'h0000, 1'b1}, // R2 entry code
    {4'd1,  1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b1}, // R1 erased value
    {4'd3,  1'b1, 16'h0004, 16'h0000, 16'h5AA5, 1'b1}, // R3 other address
    {4'd4,  1'b0, 16'h0123, 16'h00A0, 16'h0000, 1'b1}, // R4 program op
    {4'd4,  1'b0, 16'h0000, 16'hFFFE, 16'h0000, 1'b1}, // R4 value
    {4'd4,  1'b1, 16'h0000, 16'h0000, 16'hFFFE, 1'b1}, // R4 readback
    {4'd9,  1'b0, 16'h0000, 16'h77A0, 16'h0000, 1'b1}, // R9 high data byte ignored
    {4'd5,  1'b0, 16'h0000, 16'hFFFD, 16'h0000, 1'b1}, // R5 bit0 cannot return
    {4'd5,  1'b1, 16'h0000, 16'h0000, 16'hFFFC, 1'b1}, // R5 readback
    {4'd6,  1'b0, 16'h0000, 16'h00A0, 16'h0000, 1'b1}, // R6 program op
    {4'd6,  1'b0, 16'h0000, 16'hFFF8, 16'h0000, 1'b0}, // R6 conflict aborts
    {4'd6,  1'b1, 16'h0000, 16'h0000, 16'h5AA5, 1'b0}, // R6 back to array
    {4'd9,  1'b0, 16'hF555, 16'h12AA, 16'h0000, 1'b0}, // R9 high bits ignored
    {4'd9,  1'b0, 16'h3AAA, 16'hFF55, 16'h0000, 1'b0}, // R9
    {4'd9,  1'b0, 16'h8555, 16'h3440, 16'h0000, 1'b1}, // R9 entry
    {4'd6,  1'b1, 16'h0000, 16'h0000, 16'hFFFC, 1'b1}, // R6 register unchanged
    {4'd7,  1'b0, 16'h0042, 16'h0090, 16'h0000, 1'b1}, // R7 exit 1
    {4'd7,  1'b0, 16'h0017, 16'h0000, 16'h0000, 1'b0}, // R7 exit 2
    {4'd10, 1'b1, 16'h0000, 16'h0000, 16'h5AA5, 1'b0}, // R10 address 0 after exit
    {4'd8,  1'b0, 16'h0555, 16'h00AA, 16'h0000, 1'b0}, // R8 unlock 1
    {4'd8,  1'b0, 16'h02AA, 16'h0056, 16'h0000, 1'b0}, // R8 bad data breaks
    {4'd8,  1'b0, 16'h0555, 16'h0040, 16'h0000, 1'b0}, // R8 entry alone fails
    {4'd10, 1'b1, 16'h1234, 16'h0000, 16'h5AA5, 1'b0}  // R10 any address
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        in_cmd_mode;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockreg_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .in_cmd_mode(in_cmd_mode)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    #1 q = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic enter();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0040);
  endtask

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", {15'b0, in_cmd_mode}, 16'h0000);
    // R3 idle strobe gives zero
    @(negedge clk);
    bus_addr = 16'h0000; #1;
    check("R3", rd_data, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] rq;
      logic [15:0] a, d, e;
      logic isr, em;
      {rq, isr, a, d, e, em} = VEC[i];
      if (isr) begin
        rd(a, q);
        if (q !== e) begin
          vectors++; miscompares++;
          $display("FAIL R%0d vector %0d read actual=%h expected=%h", rq, i, q, e);
        end else vectors++;
      end else begin
        wr(a, d);
      end
      vectors++;
      if (in_cmd_mode !== em) begin
        miscompares++;
        $display("FAIL R%0d vector %0d mode actual=%b expected=%b", rq, i, in_cmd_mode, em);
      end
    end

    // R8 unknown command byte in command mode
    enter();
    check("R8", {15'b0, in_cmd_mode}, 16'h0001);
    wr(16'h0000, 16'h0077);
    check("R8", {15'b0, in_cmd_mode}, 16'h0000);

    // R5 program keeps cleared bits; R4 stays in mode
    enter();
    wr(16'h0000, 16'h00A0);
    wr(16'h0000, 16'h0FFF);
    check("R4", {15'b0, in_cmd_mode}, 16'h0001);
    rd(16'h0000, q);
    check("R5", q, 16'h0FFC);

    // R1 reset mid-command reloads erased value and leaves command mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", {15'b0, in_cmd_mode}, 16'h0000);
    rd(16'h0000, q);
    check("R1", q, PAT);
    enter();
    rd(16'h0000, q);
    check("R1", q, 16'hFFFF);

    // R6 only bit 2 cleared is allowed
    wr(16'h0000, 16'h00A0);
    wr(16'h0000, 16'hFFFB);
    rd(16'h0000, q);
    check("R6", q, 16'hFFFB);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule